// File: doc/BRIEF.md
# Banked In-Order Commit Unit with Late Forwarding

This block retires instructions in program order. Dispatch writes a small pointer record into a central circular queue. The record names the result bank that belongs to the executing unit, the slot offset inside that bank, and the architectural destination register. Each bank holds result values and has one write port for writeback and one read port for retirement. Banks have no ports for reading source operands.

Each cycle, up to four of the oldest records are examined in age order. A record retires only if its result has been written back, its bank's read port is still unused this cycle, and a forwarding-bus slot is free. The scan stops at the first record that fails any of these tests. Each retiring value is written to the architectural register file with its destination. The same value, together with its queue index as the tag, is also placed on a result forwarding bus that writeback is not using that cycle. Consumers that are still waiting for this producer pick it up there.

Top module: `banked_commit_unit`

## Requirements
- R1: After reset the block commits nothing, drives no forwarding bus, accepts dispatch, and reports queue index 0 for the next dispatch.
- R2: Each accepted dispatch receives the next queue index (disp_tag, counting up and wrapping at the queue depth). It also receives the next slot of the requested bank (disp_off, counting up per bank from 0).
- R3: An entry retires only after its bank slot has been written by writeback. On retirement, port arf_we[i] is set and arf_addr[i] and arf_data[i] carry that entry's destination and written value. Commit port i carries the i-th oldest pending entry.
- R4: Retirement is in order. If an entry has not retired this cycle, no younger entry retires this cycle, even when the younger entry is ready.
- R5: At most one entry per bank retires in a cycle. When two examined entries name the same bank, only the older one retires, and the scan stops at the younger one.
- R6: Up to four entries retire in one cycle when all of them are written back and name distinct banks.
- R7: Every retiring entry is driven on exactly one forwarding bus, with lf_tag equal to its queue index and lf_data equal to its value. The oldest retiring entry uses the lowest-numbered bus whose fwd_busy bit is 0, the next oldest uses the next such bus, and so on.
- R8: A bus whose fwd_busy bit is 1 is never used. Retirement in a cycle is limited to the number of free buses, so with every bus busy nothing retires.
- R9: disp_ready is low when the requested bank or the central queue is full. A dispatch attempted while disp_ready is low is ignored, so the next queue index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_bank | input | 2 | Result bank of the dispatched instruction |
| disp_dest | input | 5 | Architectural destination register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | 4 | Queue index given to the dispatch |
| disp_off | output | 2 | Slot within the bank given to the dispatch |
| wb_valid | input | 4 | Per-bank writeback strobe |
| wb_off | input | 4x2 | Per-bank writeback slot |
| wb_data | input | 4x32 | Per-bank writeback value |
| fwd_busy | input | 4 | Forwarding bus is taken by writeback this cycle |
| arf_we | output | 4 | Architectural write enable per commit port |
| arf_addr | output | 4x5 | Architectural destination per commit port |
| arf_data | output | 4x32 | Retired value per commit port |
| lf_valid | output | 4 | Late-forward drive per forwarding bus |
| lf_tag | output | 4x4 | Queue index carried on the bus |
| lf_data | output | 4x32 | Value carried on the bus |

## Verification
A corrupted queue pointer or count shows up in the same cycle on disp_tag, and a few cycles later as a wrong destination or value on the commit ports. A lost or stale done bit in a bank shows up as an entry that retires too early or never retires. Either fault then blocks every younger entry because retirement is in order. A fault in the bank or bus arbitration is visible in the very cycle it happens, as a wrong commit prefix or a value placed on a busy or wrong bus. The stimulus therefore builds windows of four entries with chosen bank patterns, writeback gaps and bus occupancy, and samples the commit and bus ports in that cycle.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int unsigned NBANK_DEF = 4;
  localparam int unsigned BANK_DEPTH_DEF = 4;
  localparam int unsigned QUEUE_DEPTH_DEF = 16;
  localparam int unsigned COMMIT_W_DEF = 4;
  localparam int unsigned NBUS_DEF = 4;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned REG_W_DEF = 5;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bcu_result_bank.sv
module bcu_result_bank
  import bcu_pkg::*;
#(
  parameter int unsigned DEPTH = BANK_DEPTH_DEF,
  parameter int unsigned DW    = DATA_W_DEF,
  localparam int unsigned OW   = idx_w(DEPTH),
  localparam int unsigned CW_C = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  output logic [OW-1:0] alloc_off,
  output logic          full,
  input  logic          wb_en,
  input  logic [OW-1:0] wb_off,
  input  logic [DW-1:0] wb_data,
  input  logic [OW-1:0] rd_off,
  input  logic          pop,
  output logic          rd_done,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0]   data_q [DEPTH];
  logic [DEPTH-1:0] done_q, done_d;
  logic [OW-1:0]   tail_q, tail_d;
  logic [CW_C-1:0] cnt_q, cnt_d;

  assign alloc_off = tail_q;
  assign full      = (cnt_q == CW_C'(DEPTH));
  assign rd_done   = done_q[rd_off];
  assign rd_data   = data_q[rd_off];

  always_comb begin
    done_d = done_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop) done_d[rd_off] = 1'b0;
    if (wb_en) done_d[wb_off] = 1'b1;
    if (alloc) begin
      done_d[tail_q] = 1'b0;
      tail_d = (tail_q == OW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    end
    if (alloc && !pop) cnt_d = cnt_q + 1'b1;
    else if (!alloc && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= done_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_en) data_q[wb_off] <= wb_data;
  end
endmodule

// File: rtl/bcu_ptr_fifo.sv
module bcu_ptr_fifo
  import bcu_pkg::*;
#(
  parameter int unsigned DEPTH = QUEUE_DEPTH_DEF,
  parameter int unsigned EW    = 9,
  parameter int unsigned WIN   = COMMIT_W_DEF,
  localparam int unsigned IW   = idx_w(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1),
  localparam int unsigned PW   = $clog2(WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [EW-1:0]           push_data,
  output logic                    full,
  output logic [IW-1:0]           tail_idx,
  input  logic [PW-1:0]           pop_cnt,
  output logic [WIN-1:0]          win_valid,
  output logic [WIN-1:0][EW-1:0]  win_data,
  output logic [WIN-1:0][IW-1:0]  win_idx
);
  logic [EW-1:0]   mem_q [DEPTH];
  logic [IW-1:0]   head_q, head_d, tail_q, tail_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  assign full     = (cnt_q == CNTW'(DEPTH));
  assign tail_idx = tail_q;

  always_comb begin
    for (int i = 0; i < int'(WIN); i++) begin
      int s;
      s = int'(head_q) + i;
      if (s >= int'(DEPTH)) s = s - int'(DEPTH);
      win_idx[i]   = IW'(s);
      win_data[i]  = mem_q[s];
      win_valid[i] = (i < int'(cnt_q));
    end
  end

  always_comb begin
    int h;
    h = int'(head_q) + int'(pop_cnt);
    if (h >= int'(DEPTH)) h = h - int'(DEPTH);
    head_d = IW'(h);
    tail_d = tail_q;
    if (push) tail_d = (tail_q == IW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    cnt_d = cnt_q + CNTW'(push) - CNTW'(pop_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[tail_q] <= push_data;
  end
endmodule

// File: rtl/bcu_commit_select.sv
module bcu_commit_select
  import bcu_pkg::*;
#(
  parameter int unsigned CW   = COMMIT_W_DEF,
  parameter int unsigned NB   = NBANK_DEF,
  parameter int unsigned NBUS = NBUS_DEF,
  localparam int unsigned BW  = idx_w(NB),
  localparam int unsigned SW  = idx_w(CW),
  localparam int unsigned PW  = $clog2(CW + 1)
) (
  input  logic [CW-1:0]          slot_valid,
  input  logic [CW-1:0][BW-1:0]  slot_bank,
  input  logic [NB-1:0]          bank_done,
  input  logic [NBUS-1:0]        fwd_busy,
  output logic [CW-1:0]          commit,
  output logic [NB-1:0]          bank_pop,
  output logic [PW-1:0]          pop_cnt,
  output logic [NBUS-1:0]        bus_en,
  output logic [NBUS-1:0][SW-1:0] bus_slot
);
  int nfree;

  always_comb begin
    nfree = 0;
    for (int j = 0; j < int'(NBUS); j++)
      if (!fwd_busy[j]) nfree = nfree + 1;
  end

  always_comb begin
    logic stop;
    logic [NB-1:0] used;
    stop     = 1'b0;
    used     = '0;
    commit   = '0;
    bank_pop = '0;
    pop_cnt  = '0;
    for (int i = 0; i < int'(CW); i++) begin
      if (!stop && slot_valid[i] && bank_done[slot_bank[i]] &&
          !used[slot_bank[i]] && (i < nfree)) begin
        commit[i]             = 1'b1;
        used[slot_bank[i]]    = 1'b1;
        bank_pop[slot_bank[i]] = 1'b1;
        pop_cnt               = pop_cnt + 1'b1;
      end else begin
        stop = 1'b1;
      end
    end
  end

  always_comb begin
    int k;
    k        = 0;
    bus_en   = '0;
    bus_slot = '0;
    for (int j = 0; j < int'(NBUS); j++) begin
      if (!fwd_busy[j] && (k < int'(CW))) begin
        bus_slot[j] = SW'(k);
        bus_en[j]   = commit[k];
        k = k + 1;
      end
    end
  end
endmodule

// File: rtl/banked_commit_unit.sv
module banked_commit_unit
  import bcu_pkg::*;
#(
  parameter int unsigned NBANK       = NBANK_DEF,
  parameter int unsigned BANK_DEPTH  = BANK_DEPTH_DEF,
  parameter int unsigned QUEUE_DEPTH = QUEUE_DEPTH_DEF,
  parameter int unsigned CW          = COMMIT_W_DEF,
  parameter int unsigned NBUS        = NBUS_DEF,
  parameter int unsigned DW          = DATA_W_DEF,
  parameter int unsigned RW          = REG_W_DEF,
  localparam int unsigned BW = idx_w(NBANK),
  localparam int unsigned OW = idx_w(BANK_DEPTH),
  localparam int unsigned TW = idx_w(QUEUE_DEPTH),
  localparam int unsigned SW = idx_w(CW),
  localparam int unsigned PW = $clog2(CW + 1),
  localparam int unsigned EW = BW + OW + RW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  input  logic [BW-1:0]              disp_bank,
  input  logic [RW-1:0]              disp_dest,
  output logic                       disp_ready,
  output logic [TW-1:0]              disp_tag,
  output logic [OW-1:0]              disp_off,
  input  logic [NBANK-1:0]           wb_valid,
  input  logic [NBANK-1:0][OW-1:0]   wb_off,
  input  logic [NBANK-1:0][DW-1:0]   wb_data,
  input  logic [NBUS-1:0]            fwd_busy,
  output logic [CW-1:0]              arf_we,
  output logic [CW-1:0][RW-1:0]      arf_addr,
  output logic [CW-1:0][DW-1:0]      arf_data,
  output logic [NBUS-1:0]            lf_valid,
  output logic [NBUS-1:0][TW-1:0]    lf_tag,
  output logic [NBUS-1:0][DW-1:0]    lf_data
);
  logic                      q_full, q_push;
  logic [PW-1:0]             pop_cnt;
  logic [CW-1:0]             win_valid;
  logic [CW-1:0][EW-1:0]     win_data;
  logic [CW-1:0][TW-1:0]     win_idx;
  logic [CW-1:0][BW-1:0]     win_bank;
  logic [CW-1:0][OW-1:0]     win_off;
  logic [CW-1:0][RW-1:0]     win_dest;

  logic [NBANK-1:0]          bank_full, bank_alloc, bank_pop, bank_done;
  logic [NBANK-1:0][OW-1:0]  bank_tail, bank_rd_off;
  logic [NBANK-1:0][DW-1:0]  bank_data;

  logic [CW-1:0]             commit;
  logic [NBUS-1:0]           bus_en;
  logic [NBUS-1:0][SW-1:0]   bus_slot;

  assign disp_ready = !q_full && !bank_full[disp_bank];
  assign q_push     = disp_valid && disp_ready;
  assign disp_off   = bank_tail[disp_bank];

  bcu_ptr_fifo #(.DEPTH(QUEUE_DEPTH), .EW(EW), .WIN(CW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_data({disp_bank, disp_off, disp_dest}),
    .full(q_full), .tail_idx(disp_tag), .pop_cnt(pop_cnt),
    .win_valid(win_valid), .win_data(win_data), .win_idx(win_idx)
  );

  always_comb begin
    for (int i = 0; i < int'(CW); i++)
      {win_bank[i], win_off[i], win_dest[i]} = win_data[i];
  end

  // Each bank's single read port is addressed by the oldest window entry naming it.
  always_comb begin
    bank_rd_off = '0;
    for (int i = int'(CW) - 1; i >= 0; i--)
      if (win_valid[i]) bank_rd_off[win_bank[i]] = win_off[i];
  end

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    assign bank_alloc[b] = q_push && (disp_bank == BW'(b));
    bcu_result_bank #(.DEPTH(BANK_DEPTH), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .alloc(bank_alloc[b]), .alloc_off(bank_tail[b]), .full(bank_full[b]),
      .wb_en(wb_valid[b]), .wb_off(wb_off[b]), .wb_data(wb_data[b]),
      .rd_off(bank_rd_off[b]), .pop(bank_pop[b]),
      .rd_done(bank_done[b]), .rd_data(bank_data[b])
    );
  end

  bcu_commit_select #(.CW(CW), .NB(NBANK), .NBUS(NBUS)) u_select (
    .slot_valid(win_valid), .slot_bank(win_bank), .bank_done(bank_done),
    .fwd_busy(fwd_busy), .commit(commit), .bank_pop(bank_pop),
    .pop_cnt(pop_cnt), .bus_en(bus_en), .bus_slot(bus_slot)
  );

  for (genvar i = 0; i < int'(CW); i++) begin : g_commit
    assign arf_we[i]   = commit[i];
    assign arf_addr[i] = win_dest[i];
    assign arf_data[i] = bank_data[win_bank[i]];
  end

  for (genvar j = 0; j < int'(NBUS); j++) begin : g_bus
    assign lf_valid[j] = bus_en[j];
    assign lf_tag[j]   = bus_en[j] ? win_idx[bus_slot[j]] : '0;
    assign lf_data[j]  = bus_en[j] ? arf_data[bus_slot[j]] : '0;
  end
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int unsigned CW   = 4,
  parameter int unsigned NBUS = 4,
  parameter int unsigned BW   = 2,
  parameter int unsigned TW   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  disp_valid,
  input logic                  disp_ready,
  input logic [TW-1:0]         disp_tag,
  input logic [NBUS-1:0]       fwd_busy,
  input logic [CW-1:0]         arf_we,
  input logic [NBUS-1:0]       lf_valid,
  input logic [CW-1:0][BW-1:0] win_bank
);
  logic same_bank;
  always_comb begin
    same_bank = 1'b0;
    for (int i = 0; i < int'(CW); i++)
      for (int j = i + 1; j < int'(CW); j++)
        if (arf_we[i] && arf_we[j] && win_bank[i] == win_bank[j]) same_bank = 1'b1;
  end

  p_inorder_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((arf_we + 1'b1) & arf_we) == '0);
  p_one_per_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !same_bank);
  p_bus_per_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lf_valid) == $countones(arf_we));
  p_busy_bus_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_valid & fwd_busy) == '0);
  p_tag_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> disp_tag == TW'($past(disp_tag) + 1'b1));
  p_blocked_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> $stable(disp_tag));
endmodule

bind banked_commit_unit bcu_checker #(.CW(CW), .NBUS(NBUS), .BW(BW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_tag(disp_tag), .fwd_busy(fwd_busy), .arf_we(arf_we),
  .lf_valid(lf_valid), .win_bank(win_bank)
);

// File: tb/banked_commit_unit_bench.sv
`timescale 1ns/1ps
module banked_commit_unit_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic disp_valid;
  logic [1:0] disp_bank;
  logic [4:0] disp_dest;
  logic disp_ready;
  logic [3:0] disp_tag;
  logic [1:0] disp_off;
  logic [3:0] wb_valid;
  logic [3:0][1:0] wb_off;
  logic [3:0][31:0] wb_data;
  logic [3:0] fwd_busy;
  logic [3:0] arf_we;
  logic [3:0][4:0] arf_addr;
  logic [3:0][31:0] arf_data;
  logic [3:0] lf_valid;
  logic [3:0][3:0] lf_tag;
  logic [3:0][31:0] lf_data;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_tag = '0;
  logic [1:0] bank_next [4] = '{default: 2'd0};
  logic [3:0] row_tag [4];
  logic [1:0] row_off [4];

  always #10 clk = ~clk;

  banked_commit_unit u_banked_commit_unit (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_bank(disp_bank),
    .disp_dest(disp_dest), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .disp_off(disp_off), .wb_valid(wb_valid), .wb_off(wb_off), .wb_data(wb_data),
    .fwd_busy(fwd_busy), .arf_we(arf_we), .arf_addr(arf_addr), .arf_data(arf_data),
    .lf_valid(lf_valid), .lf_tag(lf_tag), .lf_data(lf_data)
  );

  // Row: {bank of slot3..slot0 (2 bits each), writeback mask, busy mask, expected commit mask}
  localparam logic [19:0] VEC [8] = '{
    20'hE4F0F, 20'h90F01, 20'hE4B03, 20'hE4F53,
    20'h1BFF0, 20'hD9F03, 20'h4EE00, 20'hE4F87
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dispatch(input logic [1:0] b, input logic [4:0] d,
                          output logic [3:0] t, output logic [1:0] o);
    @(negedge clk);
    disp_valid = 1'b1; disp_bank = b; disp_dest = d;
    #1;
    check("R2 tag", 32'(disp_tag), 32'(exp_tag));
    check("R2 offset", 32'(disp_off), 32'(bank_next[b]));
    t = disp_tag; o = disp_off;
    exp_tag = exp_tag + 1'b1;
    bank_next[b] = bank_next[b] + 1'b1;
    @(posedge clk);
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic writeback(input logic [1:0] b, input logic [1:0] o, input logic [31:0] v);
    @(negedge clk);
    wb_valid = '0; wb_valid[b] = 1'b1; wb_off[b] = o; wb_data[b] = v;
    @(posedge clk);
    @(negedge clk);
    wb_valid = '0;
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; disp_valid = 1'b0; disp_bank = '0; disp_dest = '0;
    wb_valid = '0; wb_off = '0; wb_data = '0; fwd_busy = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 arf_we", 32'(arf_we), 0);
    check("R1 lf_valid", 32'(lf_valid), 0);
    check("R1 ready", 32'(disp_ready), 1);
    check("R1 tag", 32'(disp_tag), 0);

    for (int r = 0; r < 8; r++) begin
      logic [3:0] wbm, busy, expm;
      logic [1:0] bk [4];
      int k;
      wbm = VEC[r][11:8]; busy = VEC[r][7:4]; expm = VEC[r][3:0];
      for (int i = 0; i < 4; i++) bk[i] = VEC[r][12 + 2*i +: 2];
      @(negedge clk); fwd_busy = 4'hF;
      for (int i = 0; i < 4; i++) dispatch(bk[i], 5'((r*4 + i) & 31), row_tag[i], row_off[i]);
      for (int i = 0; i < 4; i++)
        if (wbm[i]) writeback(bk[i], row_off[i], 32'hC0DE0000 | 32'(r << 8) | 32'(i));
      @(negedge clk); fwd_busy = busy;
      #1;
      // R3 R4 R5 R6 R8: commit prefix from the row rules
      check("R4/R5/R6/R8 commit mask", 32'(arf_we), 32'(expm));
      for (int i = 0; i < 4; i++)
        if (expm[i]) begin
          check("R3 dest", 32'(arf_addr[i]), 32'((r*4 + i) & 31));
          check("R3 value", arf_data[i], 32'hC0DE0000 | 32'(r << 8) | 32'(i));
        end
      k = 0;
      for (int j = 0; j < 4; j++) begin
        logic ev;
        ev = 1'b0;
        if (!busy[j]) begin
          ev = expm[k];
          if (ev) begin
            check("R7 tag", 32'(lf_tag[j]), 32'(row_tag[k]));
            check("R7 data", lf_data[j], 32'hC0DE0000 | 32'(r << 8) | 32'(k));
          end
          k++;
        end
        check("R7/R8 bus use", 32'(lf_valid[j]), 32'(ev));
      end
      @(posedge clk);
      @(negedge clk); fwd_busy = '0;
      for (int i = 0; i < 4; i++)
        if (!wbm[i]) writeback(bk[i], row_off[i], 32'h0);
      repeat (6) @(posedge clk);
    end

    // R9: fill bank 2, then a blocked dispatch must be ignored
    @(negedge clk); fwd_busy = 4'hF;
    for (int i = 0; i < 4; i++) dispatch(2'd2, 5'(20 + i), row_tag[i], row_off[i]);
    @(negedge clk);
    disp_valid = 1'b1; disp_bank = 2'd2; #1;
    check("R9 full bank not ready", 32'(disp_ready), 0);
    @(posedge clk); @(negedge clk);
    disp_valid = 1'b0; #1;
    check("R9 blocked dispatch ignored", 32'(disp_tag), 32'(exp_tag));
    disp_bank = 2'd1; #1;
    check("R9 other bank ready", 32'(disp_ready), 1);
    for (int i = 0; i < 4; i++) writeback(2'd2, row_off[i], 32'(i + 100));
    @(negedge clk); fwd_busy = '0;
    // R5: same-bank entries drain one per cycle in order
    for (int c = 0; c < 4; c++) begin
      #1;
      check("R5 single commit per bank", 32'(arf_we), 1);
      check("R3 drain value", arf_data[0], 32'(c + 100));
      @(negedge clk);
    end
    #1;
    check("R4 drained", 32'(arf_we), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule